// File: doc/BRIEF.md
# Serial Clock Generator for a Multi-Select SPI Master

This block produces the serial clock of an SPI master that talks to several peripherals, one at a time. Every chip select carries its own divider field, its own idle polarity and its own phase bit. When a transfer is requested, the settings of the addressed chip select are captured. The block then runs one 8-bit transfer of serial clock edges from a source clock. That source is either the system clock or the system clock slowed by 32.

Alongside the clock it gives the data path two single-cycle strobes. The shift strobe marks the edge on which outgoing data changes. The sample strobe marks the edge on which incoming data is taken. A second, independent function watches an external serial clock in slave mode and flags any high or low phase that is too short.

Top module: `spi_sck_gen`

## Requirements
- R1: With `pre_sel` = 0 the divider counts one source tick per system clock; with `pre_sel` = 1 it counts one tick per 32 system clocks, so every half period becomes 32 times longer.
- R2: A half period of `sck` lasts exactly as many source ticks as the divider field of the active chip select (full divisor = 2 × field, 4 to 510); the first edge comes one half period after the accepting clock edge.
- R3: A divider field of 0 or 1 is treated as 2, giving the minimum divisor of 4.
- R4: The chip select named by `cs_idx` in the cycle a start is accepted alone sets divider, polarity and phase; the fields of the other chip selects have no effect.
- R5: From the accepting edge onward `sck` rests at the `cs_cpol` bit of the chosen chip select, and it is back at that level when the transfer ends.
- R6: A transfer consists of exactly 16 `sck` edges (8 bits); `busy` drops on the clock edge that makes the 16th, and `sck` then holds its level until the next accepted start.
- R7: With `cs_ncpha` = 1 the sample strobe fires on the 1st, 3rd, ... edges and the shift strobe on the 2nd, 4th, ...; with `cs_ncpha` = 0 the roles swap. Each strobe is one cycle wide, 8 per transfer, and falls in the same cycle that `sck` changes.
- R8: While `busy` is high, `start` and changes to any chip-select field are ignored, including a `start` sampled on the very edge that ends the transfer.
- R9: In slave mode (`slave_mode` = 1) a phase of `slave_sck_in` held for 2 or fewer system clocks raises `slave_viol` for one cycle; phases of 3 or more clocks, and any phase while `slave_mode` = 0, raise nothing.
- R10: During reset `sck`, `busy`, both strobes and `slave_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_sel | input | 1 | 1 selects the system clock divided by 32 as source |
| cs_div | input | NUM_CS*8 | Divider field per chip select, select i at bits [8i+7:8i] |
| cs_cpol | input | NUM_CS | Idle level of the serial clock per chip select |
| cs_ncpha | input | NUM_CS | Phase bit per chip select: 1 captures on the leading edge |
| start | input | 1 | Transfer request, accepted only when idle |
| cs_idx | input | CS_IDX_W | Index of the chip select for the requested transfer |
| slave_mode | input | 1 | Enables the phase-width check of the incoming clock |
| slave_sck_in | input | 1 | Serial clock from an external master |
| sck | output | 1 | Generated serial clock |
| shift_en | output | 1 | One-cycle strobe on each launch edge |
| sample_en | output | 1 | One-cycle strobe on each capture edge |
| busy | output | 1 | High while a transfer is in progress |
| slave_viol | output | 1 | One-cycle flag for a too-short incoming phase |

## Verification
The collision that matters is the end of a transfer and a fresh start request falling in the same clock cycle. The bench raises `start` only for the cycle whose clock edge produces the 16th `sck` edge. It then judges that `busy` stays low and `sck` stays at its idle level for the cycles that follow. A second coincidence is a reconfiguration and a start arriving mid-transfer on another chip select; the edge count, timing and final level of the running transfer must be unchanged.

// File: rtl/spi_ck_pkg.sv
package spi_ck_pkg;

  localparam int unsigned CK_FIELD_W  = 8;
  localparam int unsigned CK_MIN_HALF = 2;

  typedef logic [CK_FIELD_W-1:0] ck_field_t;

  typedef struct packed {
    ck_field_t half;
    logic      cpol;
    logic      ncpha;
    logic      pre;
  } ck_cfg_t;

  typedef enum logic {
    CK_IDLE = 1'b0,
    CK_RUN  = 1'b1
  } ck_state_t;

  // Half period in source ticks, small fields raised to the minimum.
  function automatic ck_field_t ck_half_of(input ck_field_t field);
    if (field < ck_field_t'(CK_MIN_HALF)) return ck_field_t'(CK_MIN_HALF);
    return field;
  endfunction

  // Launch edge: trailing edges when ncpha is set, leading edges otherwise.
  function automatic logic ck_is_launch(input logic ncpha, input logic leading);
    return ncpha ? ~leading : leading;
  endfunction

endpackage

// File: rtl/spi_ck_prescale.sv
module spi_ck_prescale #(
  parameter int unsigned PRESCALE = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic pre,
  output logic tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == LAST);
  assign tick = run && (!pre || wrap);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= wrap ? '0 : cnt + PW'(1);
    end
  end
endmodule

// File: rtl/spi_ck_cfg_sel.sv
module spi_ck_cfg_sel
  import spi_ck_pkg::*;
#(
  parameter int unsigned NUM_CS   = 4,
  parameter int unsigned CS_IDX_W = 2
) (
  input  logic [NUM_CS*CK_FIELD_W-1:0] cs_div,
  input  logic [NUM_CS-1:0]            cs_cpol,
  input  logic [NUM_CS-1:0]            cs_ncpha,
  input  logic                         pre_sel,
  input  logic [CS_IDX_W-1:0]          cs_idx,
  output ck_cfg_t                      cfg_sel
);
  ck_cfg_t cand [NUM_CS];

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign cand[g].half  = ck_half_of(cs_div[g*CK_FIELD_W +: CK_FIELD_W]);
      assign cand[g].cpol  = cs_cpol[g];
      assign cand[g].ncpha = cs_ncpha[g];
      assign cand[g].pre   = pre_sel;
    end
  endgenerate

  always_comb begin
    cfg_sel = cand[0];
    for (int i = 0; i < NUM_CS; i++) begin
      if (cs_idx == CS_IDX_W'(i)) cfg_sel = cand[i];
    end
  end
endmodule

// File: rtl/spi_ck_edge_gen.sv
module spi_ck_edge_gen
  import spi_ck_pkg::*;
#(
  parameter int unsigned BITS = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  ck_cfg_t cfg_sel,
  input  logic    tick,
  output ck_cfg_t cfg_l,
  output logic    busy,
  output logic    sck,
  output logic    edge_fire,
  output logic    shift_en,
  output logic    sample_en
);
  localparam int unsigned EDGES = 2 * BITS;
  localparam int unsigned EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  ck_state_t state;
  ck_field_t hcnt;
  logic [EW-1:0] ecnt;
  logic leading;
  logic launch;

  assign busy      = (state == CK_RUN);
  assign edge_fire = busy && tick && (hcnt == cfg_l.half - ck_field_t'(1));
  assign leading   = ~ecnt[0];
  assign launch    = ck_is_launch(cfg_l.ncpha, leading);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= CK_IDLE;
      hcnt      <= '0;
      ecnt      <= '0;
      sck       <= 1'b0;
      cfg_l     <= '0;
      shift_en  <= 1'b0;
      sample_en <= 1'b0;
    end else begin
      shift_en  <= edge_fire && launch;
      sample_en <= edge_fire && !launch;
      if (load) begin
        state <= CK_RUN;
        cfg_l <= cfg_sel;
        hcnt  <= '0;
        ecnt  <= '0;
        sck   <= cfg_sel.cpol;
      end else if (busy && tick) begin
        if (edge_fire) begin
          hcnt <= '0;
          sck  <= ~sck;
          ecnt <= ecnt + EW'(1);
          if (ecnt == LAST_EDGE) state <= CK_IDLE;
        end else begin
          hcnt <= hcnt + ck_field_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_ck_slave_mon.sv
module spi_ck_slave_mon #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_PHASE   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic sck_in,
  output logic phase_edge,
  output logic viol
);
  localparam int unsigned LW = $clog2(MIN_PHASE + 1);
  localparam logic [LW-1:0] LMAX = LW'(MIN_PHASE);

  logic [SYNC_STAGES-1:0] sync;
  logic                   held;
  logic [LW-1:0]          len;
  logic                   armed;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[SYNC_STAGES-2:0], sck_in};
  end

  assign phase_edge = (sync[SYNC_STAGES-1] != held);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      len   <= '0;
      armed <= 1'b0;
      viol  <= 1'b0;
    end else begin
      held <= sync[SYNC_STAGES-1];
      viol <= slave_mode && armed && phase_edge && (len < LMAX);
      if (phase_edge) len <= LW'(1);
      else if (len != LMAX) len <= len + LW'(1);
      if (!slave_mode) armed <= 1'b0;
      else if (phase_edge) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_ck_pkg::*;
#(
  parameter int unsigned NUM_CS    = 4,
  parameter int unsigned CS_IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  parameter int unsigned BITS      = 8,
  parameter int unsigned PRESCALE  = 32,
  parameter int unsigned MIN_PHASE = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pre_sel,
  input  logic [NUM_CS*CK_FIELD_W-1:0] cs_div,
  input  logic [NUM_CS-1:0]            cs_cpol,
  input  logic [NUM_CS-1:0]            cs_ncpha,
  input  logic                         start,
  input  logic [CS_IDX_W-1:0]          cs_idx,
  input  logic                         slave_mode,
  input  logic                         slave_sck_in,
  output logic                         sck,
  output logic                         shift_en,
  output logic                         sample_en,
  output logic                         busy,
  output logic                         slave_viol
);
  ck_cfg_t   cfg_sel;
  ck_cfg_t   cfg_l;
  logic      tick;
  logic      start_acc;
  logic      edge_fire;
  logic      phase_edge;
  logic      cur_cpol;
  ck_field_t cur_half;

  assign start_acc = start && !busy;
  assign cur_cpol  = cfg_l.cpol;
  assign cur_half  = cfg_l.half;

  spi_ck_cfg_sel #(.NUM_CS(NUM_CS), .CS_IDX_W(CS_IDX_W)) u_sel (
    .cs_div(cs_div), .cs_cpol(cs_cpol), .cs_ncpha(cs_ncpha),
    .pre_sel(pre_sel), .cs_idx(cs_idx), .cfg_sel(cfg_sel)
  );

  spi_ck_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start_acc), .run(busy),
    .pre(cfg_l.pre), .tick(tick)
  );

  spi_ck_edge_gen #(.BITS(BITS)) u_edge (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .cfg_sel(cfg_sel),
    .tick(tick), .cfg_l(cfg_l), .busy(busy), .sck(sck),
    .edge_fire(edge_fire), .shift_en(shift_en), .sample_en(sample_en)
  );

  spi_ck_slave_mon #(.SYNC_STAGES(2), .MIN_PHASE(MIN_PHASE)) u_mon (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .sck_in(slave_sck_in), .phase_edge(phase_edge), .viol(slave_viol)
  );
endmodule

// File: rtl/spi_sck_gen_chk.sv
module spi_sck_gen_chk
  import spi_ck_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      start_acc,
  input logic      busy,
  input logic      sck,
  input logic      shift_en,
  input logic      sample_en,
  input logic      cur_cpol,
  input ck_field_t cur_half,
  input logic      slave_mode,
  input logic      slave_viol
);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_acc) |=> $stable(sck));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && sample_en));

  // R7
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en || sample_en) |-> (sck != $past(sck)));

  // R5
  end_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sck == cur_cpol));

  // R3
  min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_half >= ck_field_t'(CK_MIN_HALF)));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cur_half) && $stable(cur_cpol)));

  // R9
  viol_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_viol |-> $past(slave_mode));
endmodule

bind spi_sck_gen spi_sck_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .busy(busy), .sck(sck),
  .shift_en(shift_en), .sample_en(sample_en), .cur_cpol(cur_cpol),
  .cur_half(cur_half), .slave_mode(slave_mode), .slave_viol(slave_viol)
);

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;
  localparam int NCS = 4;
  localparam int FW  = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              pre_sel = 1'b0;
  logic [NCS*FW-1:0] cs_div = '0;
  logic [NCS-1:0]    cs_cpol = '0;
  logic [NCS-1:0]    cs_ncpha = '0;
  logic              start = 1'b0;
  logic [1:0]        cs_idx = '0;
  logic              slave_mode = 1'b0;
  logic              slave_sck_in = 1'b0;
  logic sck, shift_en, sample_en, busy, slave_viol;

  spi_sck_gen uut (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .cs_div(cs_div),
    .cs_cpol(cs_cpol), .cs_ncpha(cs_ncpha), .start(start), .cs_idx(cs_idx),
    .slave_mode(slave_mode), .slave_sck_in(slave_sck_in), .sck(sck),
    .shift_en(shift_en), .sample_en(sample_en), .busy(busy),
    .slave_viol(slave_viol)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  // Vector: [7:0] field, [8] ncpha, [9] cpol, [10] pre, [12:11] cs, [31:16] half period in clocks
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {16'd2,   3'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'd2},
    {16'd5,   3'b0, 2'd1, 1'b0, 1'b1, 1'b1, 8'd5},
    {16'd2,   3'b0, 2'd2, 1'b0, 1'b0, 1'b1, 8'd0},
    {16'd2,   3'b0, 2'd3, 1'b0, 1'b1, 1'b0, 8'd1},
    {16'd255, 3'b0, 2'd2, 1'b0, 1'b0, 1'b0, 8'd255},
    {16'd96,  3'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'd3},
    {16'd64,  3'b0, 2'd1, 1'b1, 1'b1, 1'b0, 8'd2},
    {16'd7,   3'b0, 2'd3, 1'b0, 1'b0, 1'b1, 8'd7}
  };

  task automatic run_xfer(input int cs, input bit pre, input int field, input bit cpol,
                          input bit ncpha, input int hp, input bit mid_poke, input bit end_poke);
    int c = 0, tog = 0, first = -1, last = -1, fall = -1;
    int nsh = 0, nsa = 0, stray = 0, first_kind = -1;
    bit prev;
    string tr;
    for (int i = 0; i < NCS; i++) begin
      cs_div[i*FW +: FW] = (i == cs) ? FW'(field) : 8'd9;
      cs_cpol[i]  = (i == cs) ? cpol : ~cpol;
      cs_ncpha[i] = (i == cs) ? ncpha : ~ncpha;
    end
    pre_sel = pre;
    cs_idx  = 2'(cs);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4", "idle level after accept", int'(sck), int'(cpol));
    check("R6", "busy after accept", int'(busy), 1);
    prev = sck;
    while (busy && c < 20000) begin
      if (mid_poke && c == 3 * hp) begin
        cs_div[cs*FW +: FW] = FW'(field + 3);
        cs_cpol[cs] = ~cpol;
        cs_idx = 2'((cs + 1) % NCS);
        pre_sel = ~pre;
        start = 1'b1;
      end
      if (end_poke && c == 16 * hp - 1) start = 1'b1;
      @(negedge clk);
      c++;
      start = 1'b0;
      if (sck != prev) begin
        tog++;
        if (first < 0) first = c;
        last = c;
        if (!(shift_en ^ sample_en)) stray++;
      end else if (shift_en || sample_en) begin
        stray++;
      end
      if (shift_en) begin nsh++; if (first_kind < 0) first_kind = 0; end
      if (sample_en) begin nsa++; if (first_kind < 0) first_kind = 1; end
      if (!busy && fall < 0) fall = c;
      prev = sck;
    end
    tr = pre ? "R1" : (field < 2 ? "R3" : "R2");
    check(tr,   "first edge cycle", first, hp);
    check("R2", "last edge cycle", last, 16 * hp);
    check("R6", "edge count", tog, 16);
    check("R6", "busy fall cycle", fall, 16 * hp);
    check("R5", "level at end", int'(sck), int'(cpol));
    check("R7", "shift strobes", nsh, 8);
    check("R7", "sample strobes", nsa, 8);
    check("R7", "first strobe is sample", first_kind, int'(ncpha));
    check("R7", "strobes off an edge", stray, 0);
    if (mid_poke || end_poke) begin
      int extra = 0;
      repeat (4) begin
        @(negedge clk);
        if (busy || sck != cpol) extra++;
      end
      check("R8", "activity after ignored start", extra, 0);
    end
  endtask

  task automatic slave_phase(input int n, inout int cnt);
    slave_sck_in = ~slave_sck_in;
    repeat (n) begin
      @(negedge clk);
      cnt += int'(slave_viol);
    end
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "sck in reset", int'(sck), 0);
    check("R10", "busy in reset", int'(busy), 0);
    check("R10", "strobes in reset", int'(shift_en | sample_en), 0);
    check("R10", "viol in reset", int'(slave_viol), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      run_xfer(int'(VEC[k][12:11]), VEC[k][10], int'(VEC[k][7:0]), VEC[k][9],
               VEC[k][8], int'(VEC[k][31:16]), 1'b0, 1'b0);
      repeat (2) @(negedge clk);
    end

    // R8 mid-transfer reconfiguration and start on another select
    run_xfer(2, 1'b0, 4, 1'b1, 1'b0, 4, 1'b1, 1'b0);
    // R8 start coinciding with the final edge
    run_xfer(0, 1'b0, 2, 1'b0, 1'b1, 2, 1'b0, 1'b1);

    // R9 slave phase checks
    slave_mode = 1'b1;
    v = 0;
    slave_phase(5, v); slave_phase(5, v); slave_phase(2, v); slave_phase(5, v);
    check("R9", "short phase flagged", v, 1);
    v = 0;
    slave_phase(3, v); slave_phase(3, v); slave_phase(5, v);
    check("R9", "3-cycle phases accepted", v, 0);
    slave_mode = 1'b0;
    v = 0;
    slave_phase(1, v); slave_phase(1, v); slave_phase(5, v);
    check("R9", "no flag outside slave mode", v, 0);

    wrap_up();
  end
endmodule